// File: doc/BRIEF.md
# Fresh-Entropy Random Register Read Unit

This unit answers reads of a 64-bit random-number system register. Each read request carries the five system-register encoding fields and the requester's privilege level (0 to 3). The unit first checks whether the encoding selects its register. It then applies the trap and feature controls. The outcome is one of four: a trap to level 3, an undefined-instruction result, a completed read, or a miss for an encoding it does not own.

A completed read never reuses old state. The unit requests fresh reseed material from an entropy source and waits for it. When the material arrives, it is folded into a 64-bit internal state and the new state is returned with all four condition flags clear. If no material arrives within a bounded number of cycles, the read still completes, but with zero data and the zero flag set.

Requests enter on a valid/ready channel. `req_ready` is high only while the unit is idle, so at most one request is in flight. Back-pressure on the request side therefore lasts from acceptance until the response is taken.

Responses leave on a valid/ready channel. The response holds steady while `rsp_valid` is high and `rsp_ready` is low.

The entropy port is valid/ready as well. The unit raises `ent_ready` only while it waits for reseed material. A word moves only when `ent_valid` and `ent_ready` are high in the same cycle, and `ent_valid` at any other time has no effect.

Top module: `rng_read_unit`

## Requirements
- R1: The register is selected only when op0=2'b11, op1=3'b011, CRn=4'b0010, CRm=4'b0100 and op2=3'b001. Any other encoding is accepted and answered with trap, undefined and done all low, data zero, flags zero and class zero, and it causes no entropy request.
- R2: For a selected encoding with `feat_trap`=1 and `trap_ctl`=1, the response is a trap with `rsp_class`=6'h18. This holds at level 3 always, and at levels 0 to 2 when `sdd_undef`=0. `rsp_class` is zero in every non-trap response.
- R3: At levels 0 to 2, a trap that would apply becomes an undefined result when `sdd_undef`=1. At level 3, `sdd_undef` has no effect.
- R4: For a selected encoding where no trap applies and `feat_rng`=0, the response is undefined. This includes the case where both feature inputs are 0.
- R5: A read raises `ent_ready` and completes with done=1, flags 4'b0000 and the new state when an entropy word is taken. The new state is computed as follows.
  - Let m = state XOR entropy. If m is zero, use 64'h9E3779B97F4A7C15 instead.
  - Advance m once: x>>1 XOR (x[0] ? 64'hD800000000000000 : 0).
  - If the result equals the prior state, advance it once more.
- R6: While waiting, `ent_ready` stays high for at most TIMEOUT_CYC cycles, and a word offered in the last of them is still taken. If no word is taken, the read completes with done=1, flags 4'b0100 (flag order N,Z,C,V from bit 3 to bit 0) and data zero, and the state is unchanged.
- R7: Each successful read returns a value that differs from the value of the previous successful read. The first successful read after reset returns a nonzero value.
- R8: After reset, `req_ready`=1, `rsp_valid`=0 and `ent_ready`=0, and the state is zero. A first read that times out returns zero data with flags 4'b0100.
- R9: From acceptance until the response is taken, `req_ready` is 0. While `rsp_valid`=1 and `rsp_ready`=0, all response outputs are stable and `ent_ready` is 0, so offered entropy is not consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request offered |
| req_ready | output | 1 | Unit idle, request can be taken |
| req_op0 | input | 2 | Encoding field op0 |
| req_op1 | input | 3 | Encoding field op1 |
| req_crn | input | 4 | Encoding field CRn |
| req_crm | input | 4 | Encoding field CRm |
| req_op2 | input | 3 | Encoding field op2 |
| req_level | input | 2 | Privilege level of the requester |
| feat_rng | input | 1 | Random-number feature present |
| feat_trap | input | 1 | Trap support present |
| trap_ctl | input | 1 | Top-level trap control bit |
| sdd_undef | input | 1 | Level-3 debug-disabled undefined condition |
| ent_valid | input | 1 | Entropy word offered |
| ent_ready | output | 1 | Unit waiting for reseed material |
| ent_data | input | 64 | Entropy word |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken |
| rsp_data | output | 64 | Returned value |
| rsp_flags | output | 4 | Condition flags N,Z,C,V |
| rsp_trap | output | 1 | Trap to level 3 |
| rsp_undef | output | 1 | Undefined-instruction result |
| rsp_done | output | 1 | Read completed (success or timeout) |
| rsp_class | output | 6 | Syndrome class of a trap |

## Verification
Several properties are checked on every cycle:
- the one-hot status;
- legal flag values, with zero data whenever the timeout flags are shown;
- the trap class;
- request back-pressure and response stability;
- the bound on how long `ent_ready` stays high;
- the rule that a successful value differs from the last one.

The decode priority between trap, undefined and feature checks across levels and control settings is shown only by the bench's scenarios. The same holds for the exact mixed value, the acceptance of a word in the final wait cycle, and the state being left untouched by timeouts and by entropy offered while a response waits.

// File: rtl/rng_rd_pkg.sv
`timescale 1ns/1ps
package rng_rd_pkg;
  localparam int DATA_W = 64;

  typedef enum logic [1:0] {KIND_MISS, KIND_TRAP, KIND_UNDEF, KIND_READ} access_kind_e;

  localparam logic [1:0] SEL_OP0 = 2'b11;
  localparam logic [2:0] SEL_OP1 = 3'b011;
  localparam logic [3:0] SEL_CRN = 4'b0010;
  localparam logic [3:0] SEL_CRM = 4'b0100;
  localparam logic [2:0] SEL_OP2 = 3'b001;
  localparam logic [1:0] LVL_TOP = 2'd3;

  localparam logic [3:0] FLAGS_OK   = 4'b0000;
  localparam logic [3:0] FLAGS_FAIL = 4'b0100;

  localparam logic [DATA_W-1:0] LFSR_TAPS = 64'hD800_0000_0000_0000;
  localparam logic [DATA_W-1:0] ZERO_FILL = 64'h9E37_79B9_7F4A_7C15;

  function automatic logic [DATA_W-1:0] lfsr_adv(input logic [DATA_W-1:0] x);
    return (x >> 1) ^ (x[0] ? LFSR_TAPS : '0);
  endfunction
endpackage

// File: rtl/rng_rd_decode.sv
`timescale 1ns/1ps
module rng_rd_decode
  import rng_rd_pkg::*;
(
  input  logic [1:0]   op0,
  input  logic [2:0]   op1,
  input  logic [3:0]   crn,
  input  logic [3:0]   crm,
  input  logic [2:0]   op2,
  input  logic [1:0]   level,
  input  logic         feat_rng,
  input  logic         feat_trap,
  input  logic         trap_ctl,
  input  logic         sdd_undef,
  output access_kind_e kind
);
  logic hit;

  always_comb begin
    hit = (op0 == SEL_OP0) && (op1 == SEL_OP1) && (crn == SEL_CRN) &&
          (crm == SEL_CRM) && (op2 == SEL_OP2);
    kind = KIND_MISS;
    if (hit) begin
      if (feat_trap && trap_ctl)
        kind = ((level != LVL_TOP) && sdd_undef) ? KIND_UNDEF : KIND_TRAP;
      else if (!feat_rng)
        kind = KIND_UNDEF;
      else
        kind = KIND_READ;
    end
  end
endmodule

// File: rtl/rng_rd_timer.sv
`timescale 1ns/1ps
module rng_rd_timer #(
  parameter int LIMIT = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic tick,
  output logic expired
);
  localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  assign expired = tick && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt <= '0;
    else if (clear) cnt <= '0;
    else if (tick && !expired) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/rng_rd_mixer.sv
`timescale 1ns/1ps
module rng_rd_mixer
  import rng_rd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              absorb,
  input  logic [DATA_W-1:0] ent_word,
  output logic [DATA_W-1:0] fresh
);
  logic [DATA_W-1:0] state;
  logic [DATA_W-1:0] mixed;
  logic [DATA_W-1:0] once;

  always_comb begin
    mixed = state ^ ent_word;
    if (mixed == '0) mixed = ZERO_FILL;
    once  = lfsr_adv(mixed);
    fresh = (once == state) ? lfsr_adv(once) : once;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      state <= '0;
    else if (absorb) state <= fresh;
  end
endmodule

// File: rtl/rng_read_unit.sv
`timescale 1ns/1ps
module rng_read_unit
  import rng_rd_pkg::*;
#(
  parameter int          TIMEOUT_CYC = 1024,
  parameter int          CLASS_W     = 6,
  parameter logic [CLASS_W-1:0] TRAP_CLASS = 6'h18
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [1:0]         req_op0,
  input  logic [2:0]         req_op1,
  input  logic [3:0]         req_crn,
  input  logic [3:0]         req_crm,
  input  logic [2:0]         req_op2,
  input  logic [1:0]         req_level,
  input  logic               feat_rng,
  input  logic               feat_trap,
  input  logic               trap_ctl,
  input  logic               sdd_undef,
  input  logic               ent_valid,
  output logic               ent_ready,
  input  logic [DATA_W-1:0]  ent_data,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [DATA_W-1:0]  rsp_data,
  output logic [3:0]         rsp_flags,
  output logic               rsp_trap,
  output logic               rsp_undef,
  output logic               rsp_done,
  output logic [CLASS_W-1:0] rsp_class
);
  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_RESP} phase_e;

  phase_e            phase;
  access_kind_e      kind;
  logic              accept;
  logic              ent_fire;
  logic              expired;
  logic [DATA_W-1:0] fresh;

  assign req_ready = (phase == ST_IDLE);
  assign ent_ready = (phase == ST_WAIT);
  assign rsp_valid = (phase == ST_RESP);
  assign accept    = req_valid && req_ready;
  assign ent_fire  = ent_valid && ent_ready;

  rng_rd_decode u_decode (
    .op0(req_op0), .op1(req_op1), .crn(req_crn), .crm(req_crm), .op2(req_op2),
    .level(req_level), .feat_rng(feat_rng), .feat_trap(feat_trap),
    .trap_ctl(trap_ctl), .sdd_undef(sdd_undef), .kind(kind)
  );

  rng_rd_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .clear(accept),
    .tick(ent_ready && !ent_valid), .expired(expired)
  );

  rng_rd_mixer u_mixer (
    .clk(clk), .rst_n(rst_n), .absorb(ent_fire),
    .ent_word(ent_data), .fresh(fresh)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= ST_IDLE;
      rsp_data  <= '0;
      rsp_flags <= FLAGS_OK;
      rsp_trap  <= 1'b0;
      rsp_undef <= 1'b0;
      rsp_done  <= 1'b0;
      rsp_class <= '0;
    end else begin
      unique case (phase)
        ST_IDLE: if (accept) begin
          rsp_data  <= '0;
          rsp_flags <= FLAGS_OK;
          rsp_trap  <= (kind == KIND_TRAP);
          rsp_undef <= (kind == KIND_UNDEF);
          rsp_done  <= 1'b0;
          rsp_class <= (kind == KIND_TRAP) ? TRAP_CLASS : '0;
          phase     <= (kind == KIND_READ) ? ST_WAIT : ST_RESP;
        end
        ST_WAIT: begin
          if (ent_fire) begin
            rsp_data  <= fresh;
            rsp_flags <= FLAGS_OK;
            rsp_done  <= 1'b1;
            phase     <= ST_RESP;
          end else if (expired) begin
            rsp_data  <= '0;
            rsp_flags <= FLAGS_FAIL;
            rsp_done  <= 1'b1;
            phase     <= ST_RESP;
          end
        end
        ST_RESP: if (rsp_ready) phase <= ST_IDLE;
        default: phase <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rng_read_unit_chk.sv
`timescale 1ns/1ps
module rng_read_unit_chk #(
  parameter int TIMEOUT_CYC = 1024
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        ent_ready,
  input logic        ent_valid,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [63:0] rsp_data,
  input logic [3:0]  rsp_flags,
  input logic        rsp_trap,
  input logic        rsp_undef,
  input logic        rsp_done,
  input logic [5:0]  rsp_class
);
  localparam int WW = $clog2(TIMEOUT_CYC + 2);
  logic [WW-1:0] win;
  logic [63:0]   last_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win     <= '0;
      last_ok <= '0;
    end else begin
      win <= (ent_ready && !ent_valid) ? win + 1'b1 : '0;
      if (rsp_valid && rsp_ready && rsp_done && rsp_flags == 4'b0000)
        last_ok <= rsp_data;
    end
  end

  AST_STATUS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $onehot0({rsp_trap, rsp_undef, rsp_done})); // R1
  AST_TRAP_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_trap ? rsp_class == 6'h18 : rsp_class == 6'h00)); // R2
  AST_FLAGS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_done) |-> (rsp_flags == 4'b0000 || rsp_flags == 4'b0100)); // R5
  AST_TIMEOUT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_flags == 4'b0100) |-> rsp_data == 64'd0); // R6
  AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    ent_ready |-> win < WW'(TIMEOUT_CYC)); // R6
  AST_FRESH_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rsp_valid) && rsp_done && rsp_flags == 4'b0000) |-> rsp_data != last_ok); // R7
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid || ent_ready) |-> !req_ready); // R9
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_flags)
      && $stable(rsp_trap) && $stable(rsp_undef) && $stable(rsp_done))); // R9
  AST_NO_ENT_IN_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !ent_ready); // R9
endmodule

bind rng_read_unit rng_read_unit_chk #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .ent_ready(ent_ready),
  .ent_valid(ent_valid), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_data(rsp_data), .rsp_flags(rsp_flags), .rsp_trap(rsp_trap),
  .rsp_undef(rsp_undef), .rsp_done(rsp_done), .rsp_class(rsp_class)
);

// File: tb/rng_read_unit_test.sv
`timescale 1ns/1ps
module rng_read_unit_test;
  localparam int TO = 48;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, req_valid, req_ready;
  logic [1:0]  req_op0, req_level;
  logic [2:0]  req_op1, req_op2;
  logic [3:0]  req_crn, req_crm;
  logic        feat_rng, feat_trap, trap_ctl, sdd_undef;
  logic        ent_valid, ent_ready;
  logic [63:0] ent_data;
  logic        rsp_valid, rsp_ready;
  logic [63:0] rsp_data;
  logic [3:0]  rsp_flags;
  logic        rsp_trap, rsp_undef, rsp_done;
  logic [5:0]  rsp_class;

  int total = 0;
  int fails = 0;
  logic [63:0] model_state = '0;
  logic [63:0] prev_ok = '0;

  rng_read_unit #(.TIMEOUT_CYC(TO)) uut (.*);

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] adv(input logic [63:0] x);
    return (x >> 1) ^ (x[0] ? 64'hD800_0000_0000_0000 : 64'd0);
  endfunction

  function automatic logic [63:0] bench_mix(input logic [63:0] s, input logic [63:0] e);
    logic [63:0] m, r;
    m = s ^ e;
    if (m == 64'd0) m = 64'h9E37_79B9_7F4A_7C15;
    r = adv(m);
    if (r == s) r = adv(r);
    return r;
  endfunction

  // 0 miss, 1 trap, 2 undefined, 3 read
  function automatic int exp_kind(input logic [1:0] o0, input logic [2:0] o1,
      input logic [3:0] cn, input logic [3:0] cm, input logic [2:0] o2,
      input logic [1:0] lv, input logic fr, input logic ft, input logic tc, input logic sd);
    if (!(o0 == 2'b11 && o1 == 3'b011 && cn == 4'b0010 && cm == 4'b0100 && o2 == 3'b001))
      return 0;
    if (ft && tc) return (lv != 2'd3 && sd) ? 2 : 1;
    if (!fr) return 2;
    return 3;
  endfunction

  task automatic access(input logic [1:0] o0, input logic [2:0] o1, input logic [3:0] cn,
      input logic [3:0] cm, input logic [2:0] o2, input logic [1:0] lv,
      input logic fr, input logic ft, input logic tc, input logic sd,
      input int delay, input logic [63:0] ent, input int hold, input string tag);
    int k, w, guard;
    logic [63:0] exp_data, held;
    logic [3:0]  exp_flags;
    k = exp_kind(o0, o1, cn, cm, o2, lv, fr, ft, tc, sd);
    @(negedge clk);
    req_op0 = o0; req_op1 = o1; req_crn = cn; req_crm = cm; req_op2 = o2; req_level = lv;
    feat_rng = fr; feat_trap = ft; trap_ctl = tc; sdd_undef = sd; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    w = 0; guard = 0;
    while (!rsp_valid && guard < TO + 8) begin
      if (ent_ready) begin
        ent_valid = (w == delay);
        ent_data = ent;
        w++;
      end
      @(negedge clk);
      ent_valid = 1'b0;
      guard++;
    end
    check(rsp_valid, tag, "response present", 64'(rsp_valid), 64'd1);
    check(!req_ready, "R9", "req_ready low while response waits", 64'(req_ready), 64'd0);
    exp_data = 64'd0; exp_flags = 4'b0000;
    if (k == 3) begin
      if (delay < TO) begin
        exp_data = bench_mix(model_state, ent);
        check(w == delay + 1, tag, "entropy wait cycles", 64'(w), 64'(delay + 1));
        check(exp_data != prev_ok, "R7", "value differs from previous", exp_data, prev_ok);
        check(rsp_data != prev_ok, "R7", "returned value is fresh", rsp_data, prev_ok);
        model_state = exp_data;
        prev_ok = exp_data;
      end else begin
        exp_flags = 4'b0100;
        check(w == TO, "R6", "ent_ready window length", 64'(w), 64'(TO));
      end
    end else begin
      check(w == 0, tag, "no entropy request", 64'(w), 64'd0);
    end
    check(rsp_data == exp_data, tag, "data", rsp_data, exp_data);
    check(rsp_flags == exp_flags, tag, "flags", 64'(rsp_flags), 64'(exp_flags));
    check(rsp_trap == (k == 1), tag, "trap", 64'(rsp_trap), 64'(k == 1));
    check(rsp_undef == (k == 2), tag, "undef", 64'(rsp_undef), 64'(k == 2));
    check(rsp_done == (k == 3), tag, "done", 64'(rsp_done), 64'(k == 3));
    check(rsp_class == ((k == 1) ? 6'h18 : 6'h00), tag, "class", 64'(rsp_class),
          64'((k == 1) ? 6'h18 : 6'h00));
    held = rsp_data;
    for (int h = 0; h < hold; h++) begin
      ent_valid = 1'b1;
      ent_data = $urandom();
      @(negedge clk);
    end
    if (hold > 0) begin
      check(rsp_valid && rsp_data == held, "R9", "response held", rsp_data, held);
      check(!ent_ready, "R9", "entropy not taken while held", 64'(ent_ready), 64'd0);
    end
    ent_valid = 1'b0;
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    check(req_ready && !rsp_valid, "R9", "idle after response taken",
          64'({req_ready, rsp_valid}), 64'b10);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: actual expired expected finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240607));
    rst_n = 1'b0; req_valid = 1'b0; rsp_ready = 1'b0; ent_valid = 1'b0; ent_data = '0;
    req_op0 = '0; req_op1 = '0; req_crn = '0; req_crm = '0; req_op2 = '0; req_level = '0;
    feat_rng = 1'b1; feat_trap = 1'b1; trap_ctl = 1'b0; sdd_undef = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && !rsp_valid && !ent_ready, "R8", "reset outputs",
          64'({req_ready, rsp_valid, ent_ready}), 64'b100);

    // R8 / R6: first read times out on the cleared state
    access(2'b11, 3'b011, 4'b0010, 4'b0100, 3'b001, 2'd0, 1, 1, 0, 0, TO, 64'h1234, 0, "R8");
    // R5: zero mix falls back to the fill constant
    access(2'b11, 3'b011, 4'b0010, 4'b0100, 3'b001, 2'd1, 1, 0, 0, 0, 0, 64'd0, 0, "R5");
    // R6: word offered in the last wait cycle is taken
    access(2'b11, 3'b011, 4'b0010, 4'b0100, 3'b001, 2'd2, 1, 1, 0, 0, TO - 1,
           64'hA5A5_0F0F_1234_5678, 3, "R6");
    // R6: timeout leaves the state unchanged, checked by the next read
    access(2'b11, 3'b011, 4'b0010, 4'b0100, 3'b001, 2'd3, 1, 1, 0, 1, TO, 64'hFFFF, 0, "R6");
    access(2'b11, 3'b011, 4'b0010, 4'b0100, 3'b001, 2'd3, 1, 1, 0, 1, 2, 64'hDEAD_BEEF, 0, "R5");
    // R2 / R3 trap priority by level
    access(2'b11, 3'b011, 4'b0010, 4'b0100, 3'b001, 2'd3, 1, 1, 1, 1, 0, 64'd0, 0, "R3");
    access(2'b11, 3'b011, 4'b0010, 4'b0100, 3'b001, 2'd1, 1, 1, 1, 1, 0, 64'd0, 2, "R3");
    access(2'b11, 3'b011, 4'b0010, 4'b0100, 3'b001, 2'd0, 1, 1, 1, 0, 0, 64'd0, 0, "R2");
    access(2'b11, 3'b011, 4'b0010, 4'b0100, 3'b001, 2'd2, 0, 1, 1, 0, 0, 64'd0, 0, "R2");
    // R4: feature absent
    access(2'b11, 3'b011, 4'b0010, 4'b0100, 3'b001, 2'd1, 0, 1, 0, 0, 0, 64'd0, 0, "R4");
    access(2'b11, 3'b011, 4'b0010, 4'b0100, 3'b001, 2'd0, 0, 0, 1, 1, 0, 64'd0, 0, "R4");
    // R1: neighbouring encodings are not selected
    access(2'b11, 3'b011, 4'b0010, 4'b0100, 3'b000, 2'd0, 1, 1, 1, 0, 0, 64'd7, 0, "R1");
    access(2'b10, 3'b011, 4'b0010, 4'b0100, 3'b001, 2'd0, 1, 0, 0, 0, 0, 64'd7, 0, "R1");
    access(2'b11, 3'b011, 4'b0010, 4'b0101, 3'b001, 2'd3, 1, 0, 0, 0, 0, 64'd7, 0, "R1");

    for (int i = 0; i < 200; i++) begin
      logic [1:0] o0; logic [2:0] o1, o2; logic [3:0] cn, cm;
      int dly, sel;
      sel = $urandom_range(0, 9);
      o0 = 2'b11; o1 = 3'b011; cn = 4'b0010; cm = 4'b0100; o2 = 3'b001;
      if (sel == 0) begin
        o0 = 2'($urandom()); o1 = 3'($urandom()); cn = 4'($urandom());
        cm = 4'($urandom()); o2 = 3'($urandom());
      end
      sel = $urandom_range(0, 19);
      dly = (sel == 0) ? TO : (sel == 1) ? TO - 1 : $urandom_range(0, 6);
      access(o0, o1, cn, cm, o2, 2'($urandom()), 1'($urandom_range(0, 7) != 0),
             1'($urandom()), 1'($urandom_range(0, 3) == 0), 1'($urandom()),
             dly, {$urandom(), $urandom()}, $urandom_range(0, 2), "R5");
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule